// File: doc/BRIEF.md
# Radix-4 Sequential Signed Multiplier

This block multiplies two 36-bit two's-complement words over several clock cycles. Each cycle it consumes two multiplier bits. A one-bit memory records whether the previous step ended in a subtraction, and that bit steers the choice of the next add or subtract of one or two multiplicands. The partial product sits in a 39-bit accumulator. Each step shifts it arithmetically right by two places, together with the multiplier register, which fills with the low product bits as the multiplier bits drain out.

A start strobe captures both operands and a width select. In double-word mode the full product is returned, held to 71 significant bits and sign-extended to 72. Squaring the most negative word is flagged as overflow. In single-word mode the low word is returned, sign-extended. Overflow is flagged whenever the true product does not fit one word, and the sign of the returned word is then corrected. Single-word requests whose multiplier is below 2^17 and whose multiplicand is below 2^18 take a shortened loop of 8 steps instead of 18. A one-cycle done pulse marks each result, and the outputs hold until the next result.

Top module: `rt4_mul`

## Requirements
- R1: In double-word mode (`dbl_mode`=1), `product` equals bits 70..0 of the exact signed product of `mcand` and `mier`, with bit 70 copied into bit 71.
- R2: After every step, the step-memory bit equals the upper of the two multiplier bits just consumed. The arithmetic result is therefore exact for every multiplier bit pattern, including alternating, all-ones and all-zero patterns.
- R3: In double-word mode, `ovf` is 1 only when `mcand` and `mier` are both 0x800000000. In that case `product` reads 0xC00000000000000000.
- R4: In single-word mode (`dbl_mode`=0), `product` is the low 36 bits of the exact product, sign-extended to 72 bits. `ovf` is 1 when bits 71..35 of the exact product are not all equal, and bit 35 of the returned word is then replaced by the XOR of the operand signs.
- R5: In single-word mode with `mier` bits 35..17 and `mcand` bits 35..18 all zero, the shortened 8-step loop is used and gives the exact product.
- R6: `done` rises on the (N+1)-th rising edge after the edge that captured `start`, where N is 8 on the shortened loop and 18 otherwise.
- R7: `done` is high for exactly one cycle, and `product`, `ovf` and `mier_neg` hold their values until the next `done`.
- R8: A `start` pulse while a multiplication is in progress is ignored. The running result is unaffected.
- R9: `mier_neg` reports bit 35 of the multiplier of the last completed multiplication.
- R10: After reset `done`, `ovf`, `mier_neg` and `product` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| dbl_mode | input | 1 | 1 = double-word product, 0 = single-word product |
| mcand | input | 36 | Multiplicand, two's complement |
| mier | input | 36 | Multiplier, two's complement |
| product | output | 72 | Result, sign-extended |
| done | output | 1 | One-cycle result strobe |
| mier_neg | output | 1 | Sign of the multiplier |
| ovf | output | 1 | Overflow flag for the result |

## Verification
The bound checker watches several rules on every cycle:
- the step-memory bit tracking the consumed bit pair;
- the one-cycle width of `done`;
- the frozen multiplicand while busy;
- the count of steps per loop;
- the agreement of the overflow flag with the operand signs in both modes.

Arithmetic correctness, the exact latency seen at the ports, and the ignoring of a second start can only be shown by the bench's scenarios. These compare full results against a reference product for directed corners (most negative operands, fast-path limits, alternating bit patterns) and for seeded random operands in both modes.

// File: rtl/rt4_pkg.sv
package rt4_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD1,
        OP_ADD2,
        OP_SUB1,
        OP_SUB2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } st_e;

endpackage

// File: rtl/rt4_recoder.sv
module rt4_recoder
    import rt4_pkg::*;
(
    input  logic [1:0] pair,
    input  logic       after_sub,
    output op_e        op,
    output logic       next_sub
);

    always_comb begin
        unique case ({after_sub, pair})
            3'b000:  op = OP_NONE;
            3'b001:  op = OP_ADD1;
            3'b010:  op = OP_SUB2;
            3'b011:  op = OP_SUB1;
            3'b100:  op = OP_ADD1;
            3'b101:  op = OP_ADD2;
            3'b110:  op = OP_SUB1;
            default: op = OP_NONE;
        endcase
        // upper bit of the pair decides whether a borrow carries into the next step
        next_sub = pair[1];
    end

endmodule

// File: rtl/rt4_addend.sv
module rt4_addend
    import rt4_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = W + 3
) (
    input  logic [W-1:0]  mc,
    input  op_e           op,
    output logic [AW-1:0] addend
);

    logic [AW-1:0] one_x;
    logic [AW-1:0] two_x;

    always_comb begin
        one_x = {{(AW-W){mc[W-1]}}, mc};
        two_x = {one_x[AW-2:0], 1'b0};
        unique case (op)
            OP_ADD1: addend = one_x;
            OP_ADD2: addend = two_x;
            OP_SUB1: addend = '0 - one_x;
            OP_SUB2: addend = '0 - two_x;
            default: addend = '0;
        endcase
    end

endmodule

// File: rtl/rt4_result.sv
module rt4_result #(
    parameter int W  = 36,
    parameter int AW = W + 3,
    parameter int FS = 16
) (
    input  logic          dbl,
    input  logic          fast,
    input  logic          a_neg,
    input  logic          b_neg,
    input  logic [AW-1:0] hi,
    input  logic [W-1:0]  lo,
    output logic [2*W-1:0] product,
    output logic          ovf
);

    localparam int PW = 2 * W;

    logic [PW-1:0]  exact;
    logic [W-1:0]   word;
    logic [W:0]     upper;
    logic           fits;

    always_comb begin
        if (fast) begin
            exact = {{W{1'b0}}, hi[W-1-FS:0], lo[W-1:W-FS]};
        end else begin
            exact = {hi[W-1:0], lo};
        end

        upper = exact[PW-1:W-1];
        fits  = (&upper) | (~|upper);
        word  = exact[W-1:0];

        if (dbl) begin
            product = {exact[PW-2], exact[PW-2:0]};
            ovf     = a_neg & b_neg & exact[PW-2];
        end else begin
            ovf = ~fits;
            if (!fits) begin
                word[W-1] = a_neg ^ b_neg;
            end
            product = {{W{word[W-1]}}, word};
        end
    end

endmodule

// File: rtl/rt4_mul.sv
module rt4_mul
    import rt4_pkg::*;
#(
    parameter int W          = 36,
    parameter int FAST_STEPS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           dbl_mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mier,
    output logic [2*W-1:0] product,
    output logic           done,
    output logic           mier_neg,
    output logic           ovf
);

    localparam int LONG_STEPS = W / 2;
    localparam int AW         = W + 3;
    localparam int CW         = $clog2(LONG_STEPS) + 2;
    localparam int FS         = 2 * FAST_STEPS;
    localparam int MQF        = FS + 1;
    localparam int MCF        = W - 1 - MQF;

    typedef struct packed {
        st_e             st;
        logic [CW-1:0]   cnt;
        logic [AW-1:0]   hi;
        logic [W-1:0]    lo;
        logic            sub;
        logic [W-1:0]    mc;
        logic            dbl;
        logic            fast;
        logic            a_neg;
        logic            b_neg;
        logic [2*W-1:0]  prod;
        logic            ovf;
        logic            neg;
        logic            done;
    } regs_t;

    regs_t q, d;

    op_e             step_op;
    op_e             corr_op;
    logic            step_next_sub;
    logic [AW-1:0]   step_add;
    logic [AW-1:0]   corr_add;
    logic [AW-1:0]   hi_sum;
    logic [AW-1:0]   hi_fin;
    logic [AW+W-1:0] shifted;
    logic [1:0]      corr_v;
    logic [2*W-1:0]  res_prod;
    logic            res_ovf;
    logic            fits_fast;

    rt4_recoder u_rec (
        .pair      (q.lo[1:0]),
        .after_sub (q.sub),
        .op        (step_op),
        .next_sub  (step_next_sub)
    );

    rt4_addend #(.W(W), .AW(AW)) u_step_add (
        .mc     (q.mc),
        .op     (step_op),
        .addend (step_add)
    );

    always_comb begin
        corr_v = {1'b0, q.lo[0]} + {1'b0, q.sub};
        unique case (corr_v)
            2'd1:    corr_op = OP_ADD1;
            2'd2:    corr_op = OP_ADD2;
            default: corr_op = OP_NONE;
        endcase
    end

    rt4_addend #(.W(W), .AW(AW)) u_corr_add (
        .mc     (q.mc),
        .op     (corr_op),
        .addend (corr_add)
    );

    assign hi_fin = q.fast ? (q.hi + corr_add) : q.hi;

    rt4_result #(.W(W), .AW(AW), .FS(FS)) u_res (
        .dbl     (q.dbl),
        .fast    (q.fast),
        .a_neg   (q.a_neg),
        .b_neg   (q.b_neg),
        .hi      (hi_fin),
        .lo      (q.lo),
        .product (res_prod),
        .ovf     (res_ovf)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        hi_sum    = q.hi + step_add;
        shifted   = {{2{hi_sum[AW-1]}}, hi_sum, q.lo[W-1:2]};
        fits_fast = (mier[W-1:MQF] == '0) && (mcand[W-1:MCF] == '0);

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_RUN;
                    d.hi    = '0;
                    d.lo    = mier;
                    d.mc    = mcand;
                    d.sub   = 1'b0;
                    d.dbl   = dbl_mode;
                    d.fast  = !dbl_mode && fits_fast;
                    d.a_neg = mcand[W-1];
                    d.b_neg = mier[W-1];
                    if (!dbl_mode && fits_fast) begin
                        d.cnt = '0 - CW'(FAST_STEPS);
                    end else begin
                        d.cnt = '0 - CW'(LONG_STEPS);
                    end
                end
            end
            ST_RUN: begin
                d.hi  = shifted[AW+W-1:W];
                d.lo  = shifted[W-1:0];
                d.sub = step_next_sub;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == {CW{1'b1}}) begin
                    d.st = ST_FIN;
                end
            end
            default: begin
                d.prod = res_prod;
                d.ovf  = res_ovf;
                d.neg  = q.fast ? 1'b0 : q.sub;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign product  = q.prod;
    assign done     = q.done;
    assign mier_neg = q.neg;
    assign ovf      = q.ovf;

    logic         busy_w;
    logic         run_w;
    logic         fin_w;
    logic         sub_w;
    logic         pair_hi_w;
    logic [W-1:0] mc_w;
    logic         dbl_w;
    logic         fast_w;
    logic         a_neg_w;
    logic         b_neg_w;

    assign busy_w    = (q.st != ST_IDLE);
    assign run_w     = (q.st == ST_RUN);
    assign fin_w     = (q.st == ST_FIN);
    assign sub_w     = q.sub;
    assign pair_hi_w = q.lo[1];
    assign mc_w      = q.mc;
    assign dbl_w     = q.dbl;
    assign fast_w    = q.fast;
    assign a_neg_w   = q.a_neg;
    assign b_neg_w   = q.b_neg;

endmodule

// File: rtl/rt4_mul_chk.sv
module rt4_mul_chk #(
    parameter int W          = 36,
    parameter int FAST_STEPS = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           done,
    input logic           ovf,
    input logic           mier_neg,
    input logic [2*W-1:0] product,
    input logic           busy_w,
    input logic           run_w,
    input logic           fin_w,
    input logic           sub_w,
    input logic           pair_hi_w,
    input logic [W-1:0]   mc_w,
    input logic           dbl_w,
    input logic           fast_w,
    input logic           a_neg_w,
    input logic           b_neg_w
);

    localparam int LONG_STEPS = W / 2;
    localparam int KW         = $clog2(LONG_STEPS) + 2;

    logic [KW-1:0] runs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            runs <= '0;
        end else if (fin_w) begin
            runs <= '0;
        end else if (run_w) begin
            runs <= runs + 1'b1;
        end
    end

    // R2: the step memory follows the upper bit of the consumed pair
    p_sub_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_w |=> (sub_w == $past(pair_hi_w)));

    // R7: single-cycle strobe
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: operands frozen while busy
    p_hold_mc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && $past(busy_w)) |-> $stable(mc_w));

    // R3: double-word overflow only with both operands negative
    p_dbl_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dbl_w && ovf) |-> (mier_neg && a_neg_w));

    // R4: corrected sign on single-word overflow
    p_single_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dbl_w && ovf) |-> (product[W-1] == (a_neg_w ^ b_neg_w)));

    // R6: step count per loop
    p_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_w |-> (runs == (fast_w ? KW'(FAST_STEPS) : KW'(LONG_STEPS))));

    // R9: sign report agrees with captured multiplier
    p_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mier_neg == b_neg_w));

endmodule

bind rt4_mul rt4_mul_chk #(.W(W), .FAST_STEPS(FAST_STEPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .ovf       (ovf),
    .mier_neg  (mier_neg),
    .product   (product),
    .busy_w    (busy_w),
    .run_w     (run_w),
    .fin_w     (fin_w),
    .sub_w     (sub_w),
    .pair_hi_w (pair_hi_w),
    .mc_w      (mc_w),
    .dbl_w     (dbl_w),
    .fast_w    (fast_w),
    .a_neg_w   (a_neg_w),
    .b_neg_w   (b_neg_w)
);

// File: tb/tb_rt4_mul.sv
module tb_rt4_mul;

    localparam int CLK_PERIOD = 10;
    localparam int W = 36;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           dbl_mode = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mier = '0;
    logic [2*W-1:0] product;
    logic           done;
    logic           mier_neg;
    logic           ovf;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt4_mul dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dbl_mode (dbl_mode),
        .mcand    (mcand),
        .mier     (mier),
        .product  (product),
        .done     (done),
        .mier_neg (mier_neg),
        .ovf      (ovf)
    );

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit dbl,
                         output logic [2*W-1:0] p, output bit o, output int steps);
        logic signed [2*W-1:0] ea, eb, ex;
        logic [W-1:0] w;
        logic [W:0] up;
        ea = {{W{a[W-1]}}, a};
        eb = {{W{b[W-1]}}, b};
        ex = ea * eb;
        steps = (!dbl && b[W-1:17] == '0 && a[W-1:18] == '0) ? 8 : 18;
        if (dbl) begin
            p = {ex[2*W-2], ex[2*W-2:0]};
            o = a[W-1] & b[W-1] & ex[2*W-2];
        end else begin
            w  = ex[W-1:0];
            up = ex[2*W-1:W-1];
            o  = !((&up) || (~|up));
            if (o) w[W-1] = a[W-1] ^ b[W-1];
            p = {{W{w[W-1]}}, w};
        end
    endtask

    task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit dbl,
                          input bit poke, input string tag);
        logic [2*W-1:0] ep;
        bit eo;
        int steps;
        int k;
        model(a, b, dbl, ep, eo, steps);
        @(negedge clk);
        mcand = a; mier = b; dbl_mode = dbl; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 60) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (poke && k == 3) begin
                mcand = ~a; mier = ~b; dbl_mode = ~dbl; start = 1'b1;
            end else if (poke && k == 4) begin
                start = 1'b0;
            end
        end
        check(product == ep, {tag, (dbl ? " R1 product" : " R4 product")}, product, ep);
        check(ovf == eo, {tag, " R3/R4 ovf"}, 72'(ovf), 72'(eo));
        check(mier_neg == b[W-1], {tag, " R9 mier_neg"}, 72'(mier_neg), 72'(b[W-1]));
        check(k == steps + 1, {tag, " R6 latency"}, 72'(k), 72'(steps + 1));
        @(posedge clk);
        @(negedge clk);
        check(!done && product == ep, {tag, " R7 single pulse and hold"}, product, ep);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(!done && !ovf && !mier_neg && product == '0, "R10 reset state",
              product, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 most negative squared, and neighbours
        do_mul(36'h800000000, 36'h800000000, 1'b1, 1'b0, "R3 maxneg^2");
        check(ovf == 1'b1, "R3 ovf set", 72'(ovf), 72'd1);
        do_mul(36'h800000000, 36'hFFFFFFFFF, 1'b1, 1'b0, "R3 maxneg*-1");
        do_mul(36'h800000000, 36'h800000000, 1'b0, 1'b0, "R4 single maxneg^2");
        do_mul(36'h800000000, 36'hFFFFFFFFF, 1'b0, 1'b0, "R4 single maxneg*-1");
        do_mul(36'h7FFFFFFFF, 36'h7FFFFFFFF, 1'b0, 1'b0, "R4 single maxpos^2");
        do_mul(36'h000001234, 36'h000000056, 1'b0, 1'b0, "R4 small fits");
        // R2 recoding patterns
        do_mul(36'h123456789, 36'hAAAAAAAAA, 1'b1, 1'b0, "R2 alt10");
        do_mul(36'h9ABCDEF01, 36'h555555555, 1'b1, 1'b0, "R2 alt01");
        do_mul(36'h0F0F0F0F0, 36'hFFFFFFFFF, 1'b1, 1'b0, "R2 ones");
        do_mul(36'hFFFFFFFFF, 36'h000000000, 1'b1, 1'b0, "R2 zeros");
        do_mul(36'h3C3C3C3C3, 36'hCCCCCCCCC, 1'b1, 1'b0, "R2 pairs");
        // R5 fast path limits
        do_mul(36'h00003FFFF, 36'h00001FFFF, 1'b0, 1'b0, "R5 fast max");
        do_mul(36'h00003FFFF, 36'h00001AAAA, 1'b0, 1'b0, "R5 fast alt");
        do_mul(36'h000000001, 36'h000010000, 1'b0, 1'b0, "R5 fast bit16");
        do_mul(36'h000040000, 36'h00001FFFF, 1'b0, 1'b0, "R5 not fast mc");
        do_mul(36'h00003FFFF, 36'h000020000, 1'b0, 1'b0, "R5 not fast mq");
        do_mul(36'h00003FFFF, 36'h00001FFFF, 1'b1, 1'b0, "R5 dbl no fast");
        // R8 ignored start while busy
        do_mul(36'h876543210, 36'h0DEADBEEF, 1'b1, 1'b1, "R8 long poke");
        do_mul(36'h000012345, 36'h000006789, 1'b0, 1'b1, "R8 fast poke");

        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a, b;
            bit dbl;
            a   = {4'($urandom()), 32'($urandom())};
            b   = {4'($urandom()), 32'($urandom())};
            dbl = 1'($urandom());
            if ($urandom() % 4 == 0) begin
                a = a & 36'h00003FFFF;
                b = b & 36'h00001FFFF;
            end
            do_mul(a, b, dbl, 1'b0, "R1 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule